// File: doc/BRIEF.md
# Cache Block Buffer Filter

This block sits between a CPU-side request port and the tag and data arrays of a set-associative cache. It holds one cache block (the one most recently fetched from the arrays) together with that block's set index, its tag and a valid flag. Each read request is compared against the held set index and tag. On a match the requested word comes straight out of the held block in the same cycle, and the array enable stays low, so neither the tag array nor the data array senses anything. On a mismatch the request goes to the arrays. When the array answers, the requested word is returned and the whole block is captured as the new buffer content.

Writes always go to the arrays. A write that lands on the buffered set, or an invalidation of that set, drops the buffer so that stale data can never be returned. A free-running counter reports how many reads were served from the buffer, which is the number of array accesses that were avoided.

The controller is a three-state machine:
- `ST_IDLE` accepts requests.
- `ST_FILL` waits for a read miss to be answered.
- `ST_ACK` waits for a write to be acknowledged.

Its transitions are:
- `IDLE->FILL` on an accepted read that misses the buffer.
- `IDLE->ACK` on an accepted write.
- `FILL->IDLE` and `ACK->IDLE` in the cycle the array raises its response.
- A read that hits the buffer keeps the machine in `ST_IDLE`.

Top module: `blkbuf_filter`

## Requirements
- R1: After reset the buffer is empty, `hit_count` is 0, `rsp_valid` and `arr_en` are 0 and `req_ready` is 1.
- R2: A read that misses raises `arr_en` for exactly the accept cycle, with `arr_we`=0 and `arr_addr` equal to the request address. The read is answered with `rsp_valid` in the cycle `arr_rsp_valid` is high. The answer carries word `off` of `arr_rsp_blk`, where word k occupies bits [32k+31:32k] and the address is {tag[15:6], set[5:2], off[1:0]}.
- R3: A read whose set and tag both equal the buffered ones, while the buffer is valid, is answered in its accept cycle with the buffered word for its offset, and `arr_en` stays 0. This holds for every offset.
- R4: A read with the buffered set but another tag misses, as does a read with another set. Its block then replaces the buffer content.
- R5: A write raises `arr_en` and `arr_we` in its accept cycle and is acknowledged by `rsp_valid` with `arr_rsp_valid`. A write to the buffered set empties the buffer, so the next read to that block misses.
- R6: A write to a set other than the buffered one leaves the buffer valid.
- R7: `inval_valid` with `inval_idx` equal to the buffered set empties the buffer. With another set it has no effect.
- R8: An invalidation of the set of a read miss that is still waiting for the array lets that read complete with the array data, but the block is not captured.
- R9: `hit_count` rises by one for each read served from the buffer and is unchanged by misses and writes.
- R10: While a miss or a write is outstanding, `req_ready` is 0 and a held request does not raise `arr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address {tag, set, offset} |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data or write acknowledge |
| rsp_rdata | output | 32 | Read word |
| inval_valid | input | 1 | Invalidate a cache set |
| inval_idx | input | 4 | Set being invalidated |
| arr_en | output | 1 | Tag and data array access and sense enable |
| arr_we | output | 1 | Array write |
| arr_addr | output | 16 | Array address |
| arr_wdata | output | 32 | Array write data |
| arr_rsp_valid | input | 1 | Array answer or acknowledge |
| arr_rsp_blk | input | 128 | Block returned by the array |
| hit_count | output | 16 | Reads served from the buffer |

## Verification
The bench reads every offset of a held block and checks the data in the accept cycle with the array enable low. A design that added a cycle, or still pulsed the arrays, fails there.

It then probes the comparison:
- Same set with a different tag: a design that compared only the set number returns a wrong word.
- Writes and invalidations to the buffered set and to other sets: a design that ignored these returns stale data, and one that cleared on any set loses hits it should have kept.
- An invalidation that arrives while a fill is outstanding, followed by a reread: a design that captured the fill anyway answers the reread from the buffer.

Finally, a request is held high during a pending miss. This shows that a controller which accepts it early drives the arrays twice.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_ACK  = 2'd2
    } bb_state_t;

endpackage

// File: rtl/blkbuf_store.sv
module blkbuf_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 10,
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [TAG_W-1:0] load_tag,
    input  logic [BLK_W-1:0] load_blk,
    input  logic             wr_clear,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             inv_valid,
    input  logic [IDX_W-1:0] inv_idx,
    output logic             vld,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag,
    output logic [BLK_W-1:0] blk
);

    logic drop;
    assign drop = (wr_clear && (wr_idx == idx)) || (inv_valid && (inv_idx == idx));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            idx <= '0;
            tag <= '0;
        end else if (load) begin
            vld <= 1'b1;
            idx <= load_idx;
            tag <= load_tag;
        end else if (drop) begin
            vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            blk <= load_blk;
        end
    end

    // R7
    property inval_drops_p;
        @(posedge clk) disable iff (!rst_n)
        (inv_valid && vld && (inv_idx == idx) && !load) |=> !vld;
    endproperty
    inval_drops_chk: assert property (inval_drops_p);

    // R5
    property write_drops_p;
        @(posedge clk) disable iff (!rst_n)
        (wr_clear && vld && (wr_idx == idx) && !load) |=> !vld;
    endproperty
    write_drops_chk: assert property (write_drops_p);

endmodule

// File: rtl/blkbuf_match.sv
module blkbuf_match #(
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 10,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int OFF_W     = 2
) (
    input  logic                        vld,
    input  logic [IDX_W-1:0]            buf_idx,
    input  logic [TAG_W-1:0]            buf_tag,
    input  logic [IDX_W-1:0]            req_idx,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic [WORD_W*BLK_WORDS-1:0] src_blk,
    input  logic [OFF_W-1:0]            sel_off,
    output logic                        hit,
    output logic [WORD_W-1:0]           word
);

    logic [WORD_W-1:0] lane [BLK_WORDS];

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_lane
        assign lane[g] = src_blk[g*WORD_W +: WORD_W];
    end

    assign hit  = vld && (buf_idx == req_idx) && (buf_tag == req_tag);
    assign word = lane[sel_off];

endmodule

// File: rtl/blkbuf_hitcnt.sv
module blkbuf_hitcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    // R9
    property count_step_p;
        @(posedge clk) disable iff (!rst_n)
        inc |=> (count == $past(count) + CNT_W'(1));
    endproperty
    count_step_chk: assert property (count_step_p);

    // R9
    property count_hold_p;
        @(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count);
    endproperty
    count_hold_chk: assert property (count_hold_p);

endmodule

// File: rtl/blkbuf_ctrl.sv
module blkbuf_ctrl
    import blkbuf_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 10,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [OFF_W-1:0] req_off,
    input  logic             buf_hit,
    input  logic             inval_valid,
    input  logic [IDX_W-1:0] inval_idx,
    input  logic             arr_rsp_valid,
    output logic             req_ready,
    output logic             arr_en,
    output logic             arr_we,
    output logic             rsp_valid,
    output logic             fill_sel,
    output logic             buf_load,
    output logic             wr_clear,
    output logic             hit_take,
    output logic [IDX_W-1:0] pend_idx,
    output logic [TAG_W-1:0] pend_tag,
    output logic [OFF_W-1:0] pend_off
);

    bb_state_t state, state_nx;
    logic      kill;
    logic      inv_pend;

    assign inv_pend = inval_valid && (inval_idx == pend_idx);

    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        arr_en    = 1'b0;
        arr_we    = 1'b0;
        rsp_valid = 1'b0;
        fill_sel  = 1'b0;
        buf_load  = 1'b0;
        wr_clear  = 1'b0;
        hit_take  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (req_we) begin
                        arr_en   = 1'b1;
                        arr_we   = 1'b1;
                        wr_clear = 1'b1;
                        state_nx = ST_ACK;
                    end else if (buf_hit) begin
                        hit_take  = 1'b1;
                        rsp_valid = 1'b1;
                    end else begin
                        arr_en   = 1'b1;
                        state_nx = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                fill_sel = 1'b1;
                if (arr_rsp_valid) begin
                    rsp_valid = 1'b1;
                    buf_load  = !kill && !inv_pend;
                    state_nx  = ST_IDLE;
                end
            end
            ST_ACK: begin
                if (arr_rsp_valid) begin
                    rsp_valid = 1'b1;
                    state_nx  = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kill     <= 1'b0;
            pend_idx <= '0;
            pend_tag <= '0;
            pend_off <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            kill     <= 1'b0;
            pend_idx <= req_idx;
            pend_tag <= req_tag;
            pend_off <= req_off;
        end else if (state == ST_FILL && inv_pend) begin
            kill <= 1'b1;
        end
    end

    // R2
    property arr_single_pulse_p;
        @(posedge clk) disable iff (!rst_n)
        arr_en |=> !arr_en;
    endproperty
    arr_single_pulse_chk: assert property (arr_single_pulse_p);

    // R3
    property hit_no_array_p;
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we && buf_hit) |-> (!arr_en && rsp_valid);
    endproperty
    hit_no_array_chk: assert property (hit_no_array_p);

    // R10
    property busy_blocks_p;
        @(posedge clk) disable iff (!rst_n)
        !req_ready |-> !arr_en;
    endproperty
    busy_blocks_chk: assert property (busy_blocks_p);

    // R8
    property kill_no_load_p;
        @(posedge clk) disable iff (!rst_n)
        (fill_sel && inv_pend && !arr_rsp_valid) |=> !buf_load;
    endproperty
    kill_no_load_chk: assert property (kill_no_load_p);

endmodule

// File: rtl/blkbuf_filter.sv
module blkbuf_filter
    import blkbuf_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int SET_NUM   = 16,
    parameter int CNT_W     = 16,
    parameter int IDX_W     = $clog2(SET_NUM),
    parameter int BLK_W     = WORD_W * BLK_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              inval_valid,
    input  logic [IDX_W-1:0]  inval_idx,
    output logic              arr_en,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [WORD_W-1:0] arr_wdata,
    input  logic              arr_rsp_valid,
    input  logic [BLK_W-1:0]  arr_rsp_blk,
    output logic [CNT_W-1:0]  hit_count
);

    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;

    assign req_off = req_addr[OFF_W-1:0];
    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    logic             buf_vld;
    logic [IDX_W-1:0] buf_idx;
    logic [TAG_W-1:0] buf_tag;
    logic [BLK_W-1:0] buf_blk;
    logic             buf_hit;
    logic             fill_sel;
    logic             buf_load;
    logic             wr_clear;
    logic             hit_take;
    logic [IDX_W-1:0] pend_idx;
    logic [TAG_W-1:0] pend_tag;
    logic [OFF_W-1:0] pend_off;
    logic [BLK_W-1:0] src_blk;
    logic [OFF_W-1:0] sel_off;

    assign src_blk   = fill_sel ? arr_rsp_blk : buf_blk;
    assign sel_off   = fill_sel ? pend_off : req_off;
    assign arr_addr  = req_addr;
    assign arr_wdata = req_wdata;

    blkbuf_ctrl #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we),
        .req_idx(req_idx), .req_tag(req_tag), .req_off(req_off),
        .buf_hit(buf_hit),
        .inval_valid(inval_valid), .inval_idx(inval_idx),
        .arr_rsp_valid(arr_rsp_valid),
        .req_ready(req_ready), .arr_en(arr_en), .arr_we(arr_we),
        .rsp_valid(rsp_valid), .fill_sel(fill_sel), .buf_load(buf_load),
        .wr_clear(wr_clear), .hit_take(hit_take),
        .pend_idx(pend_idx), .pend_tag(pend_tag), .pend_off(pend_off)
    );

    blkbuf_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .load(buf_load), .load_idx(pend_idx), .load_tag(pend_tag),
        .load_blk(arr_rsp_blk),
        .wr_clear(wr_clear), .wr_idx(req_idx),
        .inv_valid(inval_valid), .inv_idx(inval_idx),
        .vld(buf_vld), .idx(buf_idx), .tag(buf_tag), .blk(buf_blk)
    );

    blkbuf_match #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .WORD_W(WORD_W),
        .BLK_WORDS(BLK_WORDS), .OFF_W(OFF_W)
    ) u_match (
        .vld(buf_vld), .buf_idx(buf_idx), .buf_tag(buf_tag),
        .req_idx(req_idx), .req_tag(req_tag),
        .src_blk(src_blk), .sel_off(sel_off),
        .hit(buf_hit), .word(rsp_rdata)
    );

    blkbuf_hitcnt #(
        .CNT_W(CNT_W)
    ) u_hitcnt (
        .clk(clk), .rst_n(rst_n), .inc(hit_take), .count(hit_count)
    );

endmodule

// File: tb/blkbuf_filter_test.sv
`timescale 1ns/1ps
module blkbuf_filter_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_we = 1'b0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         inval_valid = 1'b0;
    logic [3:0]   inval_idx = '0;
    logic         arr_en;
    logic         arr_we;
    logic [15:0]  arr_addr;
    logic [31:0]  arr_wdata;
    logic         arr_rsp_valid = 1'b0;
    logic [127:0] arr_rsp_blk = '0;
    logic [15:0]  hit_count;

    int checks = 0;
    int failures = 0;
    int exp_hits = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    blkbuf_filter uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .inval_valid(inval_valid), .inval_idx(inval_idx),
        .arr_en(arr_en), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_rsp_valid(arr_rsp_valid),
        .arr_rsp_blk(arr_rsp_blk), .hit_count(hit_count)
    );

    // ---------------- array model ----------------
    logic [31:0] wmem [int];
    logic [15:0] m_addr;
    bit          m_busy = 0;
    int          m_cnt = 0;

    function automatic logic [31:0] pat(input logic [15:0] a);
        return 32'hC0DE_0000 ^ ({16'h0, a} * 32'h0000_9E37);
    endfunction

    function automatic logic [31:0] exp_word(input logic [15:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return pat(a);
    endfunction

    function automatic logic [15:0] mk(input int tg, input int ix, input int of);
        return {tg[9:0], ix[3:0], of[1:0]};
    endfunction

    always @(negedge clk) begin
        arr_rsp_valid <= 1'b0;
        if (m_busy) begin
            if (m_cnt == 0) begin
                arr_rsp_valid <= 1'b1;
                for (int k = 0; k < 4; k++)
                    arr_rsp_blk[k*32 +: 32] <= exp_word({m_addr[15:2], k[1:0]});
                m_busy = 0;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end else if (rst_n && arr_en) begin
            if (arr_we) wmem[int'(arr_addr)] = arr_wdata;
            m_addr = arr_addr;
            m_cnt  = 2;
            m_busy = 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_rsp(input string req, input bit is_rd, input logic [31:0] exp);
        bit got = 0;
        for (int n = 0; n < 20 && !got; n++) begin
            #2;
            if (rsp_valid) begin
                got = 1;
                if (is_rd) chk(rsp_rdata == exp, req, rsp_rdata, exp);
            end else begin
                chk(req_ready == 1'b0, {req, " busy"}, {31'h0, req_ready}, 32'h0);
                @(posedge clk); #1;
            end
        end
        chk(got, {req, " response"}, {31'h0, got}, 32'h1);
    endtask

    task automatic rd(input logic [15:0] a, input bit exp_hit, input string req);
        @(posedge clk); #1;
        req_valid = 1; req_we = 0; req_addr = a;
        #2;
        if (exp_hit) begin
            chk(rsp_valid && !arr_en && rsp_rdata == exp_word(a), {req, " hit"},
                rsp_rdata, exp_word(a));
            exp_hits++;
        end else begin
            chk(arr_en && !arr_we && arr_addr == a && !rsp_valid, {req, " miss"},
                {15'h0, arr_en, arr_addr}, {15'h0, 1'b1, a});
        end
        @(posedge clk); #1;
        req_valid = 0;
        if (!exp_hit) wait_rsp(req, 1, exp_word(a));
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string req);
        @(posedge clk); #1;
        req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
        #2;
        chk(arr_en && arr_we && arr_addr == a && arr_wdata == d, {req, " write"},
            arr_wdata, d);
        @(posedge clk); #1;
        req_valid = 0; req_we = 0;
        wait_rsp(req, 0, 32'h0);
    endtask

    task automatic inv(input int ix);
        @(posedge clk); #1;
        inval_valid = 1; inval_idx = ix[3:0];
        @(posedge clk); #1;
        inval_valid = 0;
    endtask

    task automatic chk_hits(input string req);
        @(posedge clk); #3;
        chk(hit_count == exp_hits[15:0], {req, " hit_count"}, {16'h0, hit_count}, exp_hits);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        #3;
        chk(hit_count == 0 && !rsp_valid && !arr_en && req_ready, "R1 reset",
            {hit_count, 13'h0, rsp_valid, arr_en, req_ready}, 32'h1);
    endtask

    task automatic t_first_miss();
        rd(mk(5, 3, 2), 0, "R2");
    endtask

    task automatic t_hits();
        for (int o = 0; o < 4; o++) rd(mk(5, 3, o), 1, "R3");
        chk_hits("R9 after hits");
    endtask

    task automatic t_conflicts();
        rd(mk(6, 3, 1), 0, "R4 same set other tag");
        rd(mk(6, 3, 3), 1, "R4 new block held");
        rd(mk(6, 7, 0), 0, "R4 other set");
        rd(mk(6, 3, 0), 0, "R4 replaced");
        chk_hits("R9 misses do not count");
    endtask

    task automatic t_write_same();
        rd(mk(9, 4, 0), 0, "R5 load");
        wr(mk(9, 4, 2), 32'hDEAD_BEEF, "R5");
        rd(mk(9, 4, 2), 0, "R5 reread after write");
        rd(mk(9, 4, 1), 1, "R5 refilled");
    endtask

    task automatic t_write_other();
        wr(mk(9, 11, 0), 32'h1234_5678, "R6");
        rd(mk(9, 4, 3), 1, "R6 still held");
    endtask

    task automatic t_inval();
        inv(2);
        rd(mk(9, 4, 0), 1, "R7 other set ignored");
        inv(4);
        rd(mk(9, 4, 0), 0, "R7 matching set dropped");
    endtask

    task automatic t_inval_pending();
        logic [15:0] a;
        a = mk(12, 8, 1);
        @(posedge clk); #1;
        req_valid = 1; req_we = 0; req_addr = a;
        @(posedge clk); #1;
        req_valid = 0;
        inval_valid = 1; inval_idx = 4'd8;
        @(posedge clk); #1;
        inval_valid = 0;
        #2;
        chk(rsp_valid || !req_ready, "R8 pending", {31'h0, req_ready}, 32'h0);
        if (!rsp_valid) begin
            @(posedge clk); #1;
        end else begin
            #(-2);
        end
        wait_rsp("R8 data", 1, exp_word(a));
        rd(a, 0, "R8 not captured");
    endtask

    task automatic t_busy();
        logic [15:0] a, b;
        bit got;
        a = mk(20, 1, 0);
        b = mk(21, 2, 3);
        @(posedge clk); #1;
        req_valid = 1; req_we = 0; req_addr = a;
        @(posedge clk); #1;
        req_addr = b;
        got = 0;
        for (int n = 0; n < 20 && !got; n++) begin
            #2;
            if (rsp_valid) begin
                got = 1;
                chk(rsp_rdata == exp_word(a), "R10 first data", rsp_rdata, exp_word(a));
            end else begin
                chk(!req_ready && !arr_en, "R10 held request blocked",
                    {30'h0, req_ready, arr_en}, 32'h0);
                @(posedge clk); #1;
            end
        end
        chk(got, "R10 first response", {31'h0, got}, 32'h1);
        @(posedge clk); #1;
        #2;
        chk(arr_en && arr_addr == b, "R10 held request accepted later", {16'h0, arr_addr}, {16'h0, b});
        @(posedge clk); #1;
        req_valid = 0;
        wait_rsp("R10 second", 1, exp_word(b));
        chk_hits("R9 final");
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #1 rst_n = 1;
        t_first_miss();
        t_hits();
        t_conflicts();
        t_write_same();
        t_write_other();
        t_inval();
        t_inval_pending();
        t_busy();
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule